// File: doc/BRIEF.md
# Serial Auto-Baud Boot Handshake

This block watches an asynchronous serial receive line after reset and works out the host's bit rate. The host sends a stream of zero characters. In the 8N1 format used here (8 data bits, one stop bit, no parity), a zero character is one unbroken low run of nine bit times: the start bit and eight zero data bits. The block counts the clocks of that low run and divides by nine, rounding to the nearest integer, to get the bit period. It then waits for the line to stay high for at least one bit period so that it knows the run was a complete character.

If the period falls inside the legal window, the block loads it into a shared baud divisor. It transmits one zero character on its transmit line as the sign that adjustment is done. It then listens for a single confirm byte of 0x55 from the host. A correct confirm locks the block for good. A wrong byte, a missing stop bit, or silence past a timeout raises the error flag and sends the block back to measuring, which acts as a retry without a reset. Zero characters that keep arriving while the sign is being sent have no effect.

The default window covers host rates of 9600 and 19200 bit/s on a 20 to 25 MHz clock, which gives a divisor of 1000 to 2700 clocks per bit. The receive input passes through a two-flop synchroniser before any logic uses it.

Top module: `autobaud_handshake`

## Requirements
- R1: While reset is held and on the first cycle after it, `tx_o` is 1 and `locked_o`, `err_o` and `div_o` are all 0.
- R2: For a low run of L clocks on `rx_i`, the divisor loaded into `div_o` is (L+4)/9 in integer arithmetic, which is L/9 rounded to the nearest integer.
- R3: A low run counts only after `rx_i` has been high for at least as many clocks as its divisor. If the line falls again sooner, the earlier run is discarded and the new run is measured from its own falling edge.
- R4: If the rounded divisor is below MIN_DIV or above MAX_DIV, `err_o` is set, nothing is transmitted and measuring continues. `div_o` is always within the window while `locked_o` is 1.
- R5: After a run is accepted, exactly one 8N1 character 0x00 is sent on `tx_o`. Each bit lasts `div_o` clocks, so the line is low for 9×`div_o` clocks and then high for the stop bit.
- R6: A confirm byte of 0x55 (LSB first, with a high stop bit) received at the new rate after the sign sets `locked_o`. `locked_o` stays 1 until reset, with `err_o` at 0.
- R7: Any other confirm byte, or a confirm byte whose stop bit is low, sets `err_o`, leaves `locked_o` at 0 and returns the block to measuring.
- R8: If no confirm byte completes within TIMEOUT_CLKS clocks of the end of the sign, `err_o` is set and the block returns to measuring.
- R9: Once a run is accepted, later activity on `rx_i` does not change `div_o` until the block is measuring again. This includes zero characters at another rate sent while the sign is going out.
- R10: `err_o` stays set until a later run is accepted, and is cleared on that acceptance.
- R11: `tx_o` is high at all times except during the sign character. While locked, nothing more is transmitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial receive line from the host, idle high |
| tx_o | output | 1 | Serial transmit line to the host, idle high |
| locked_o | output | 1 | Handshake complete; rate fixed until reset |
| err_o | output | 1 | Last attempt failed: rate out of range, bad confirm, or timeout |
| div_o | output | $clog2(MAX_DIV+1) | Clocks per bit, as computed from the last accepted run |

## Verification
The assertions assume that reset is held from time zero and that `rx_i` is either idle high or carries whole low and high runs of at least one clock. They also assume that MIN_DIV is at least one, so a divisor is never zero while the transmitter or receiver is running.

The stimulus keeps to these assumptions in several ways:
- It drives `rx_i` one clock at a time on the falling clock edge.
- It uses a window of 8 to 40 clocks per bit, so every divisor stays small.
- It sends the host's confirm byte only after the sign's stop bit has ended.
- It sends the extra zero character at a shorter rate, so that character finishes before the sign does. The receiver therefore never sees a character cut in half.

// File: rtl/abh_pkg.sv
package abh_pkg;

    localparam int unsigned LOW_BITS     = 9;
    localparam logic [7:0]  SIGN_BYTE    = 8'h00;
    localparam logic [7:0]  CONFIRM_BYTE = 8'h55;

    typedef enum logic [2:0] {
        ST_MEASURE,
        ST_SEND,
        ST_WAIT_TX,
        ST_CONFIRM,
        ST_LOCKED
    } hs_state_t;

    typedef enum logic [1:0] {
        MT_IDLE,
        MT_ARMED,
        MT_LOW,
        MT_HIGH
    } meter_state_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

    typedef struct packed {
        logic [7:0] data;
        logic       stop_ok;
    } rx_frame_t;

    // Nine-bit low run to one bit period, rounded to nearest.
    function automatic int unsigned round_div_low(input int unsigned n);
        return (n + LOW_BITS / 2) / LOW_BITS;
    endfunction

endpackage

// File: rtl/abh_sync.sv
module abh_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/abh_meter.sv
module abh_meter
    import abh_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          line,
    output logic          meas_v,
    output logic [CW-1:0] meas_per
);
    meter_state_t  st;
    logic [CW-1:0] low_cnt;
    logic [CW-1:0] high_cnt;
    logic [CW-1:0] per;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st       <= MT_IDLE;
            low_cnt  <= '0;
            high_cnt <= '0;
            per      <= '0;
            meas_v   <= 1'b0;
        end else begin
            meas_v <= 1'b0;
            case (st)
                MT_IDLE: begin
                    if (line) st <= MT_ARMED;
                end
                MT_ARMED: begin
                    if (!line) begin
                        st      <= MT_LOW;
                        low_cnt <= CW'(1);
                    end
                end
                MT_LOW: begin
                    if (!line) begin
                        if (low_cnt != '1) low_cnt <= low_cnt + CW'(1);
                    end else begin
                        st       <= MT_HIGH;
                        high_cnt <= CW'(1);
                        per      <= CW'(round_div_low(32'(low_cnt)));
                    end
                end
                MT_HIGH: begin
                    if (!line) begin
                        st      <= MT_LOW;
                        low_cnt <= CW'(1);
                    end else if (high_cnt >= per) begin
                        meas_v <= 1'b1;
                        st     <= MT_ARMED;
                    end else begin
                        high_cnt <= high_cnt + CW'(1);
                    end
                end
                default: st <= MT_IDLE;
            endcase
        end
    end

    assign meas_per = per;

    // R3: a result is only offered after the line was seen high
    assert_accept_after_high_R3: assert property (@(posedge clk) disable iff (rst)
        meas_v |-> $past(line));
endmodule

// File: rtl/abh_tx.sv
module abh_tx #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [7:0]    data,
    input  logic [DW-1:0] div,
    output logic          tx,
    output logic          busy,
    output logic          done
);
    logic [8:0]    sh;
    logic [DW-1:0] cnt;
    logic [3:0]    nbit;
    logic          tx_q;
    logic          busy_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '1;
            cnt    <= '0;
            nbit   <= '0;
            tx_q   <= 1'b1;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    sh     <= {1'b1, data};
                    tx_q   <= 1'b0;
                    cnt    <= div - DW'(1);
                    nbit   <= '0;
                    busy_q <= 1'b1;
                end
            end else if (cnt == '0) begin
                if (nbit == 4'd9) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    tx_q   <= 1'b1;
                end else begin
                    tx_q <= sh[0];
                    sh   <= {1'b1, sh[8:1]};
                    nbit <= nbit + 4'd1;
                    cnt  <= div - DW'(1);
                end
            end else begin
                cnt <= cnt - DW'(1);
            end
        end
    end

    assign tx   = tx_q;
    assign busy = busy_q;
    assign done = done_q;

    // R11: line rests high whenever no character is in flight
    assert_idle_line_high_R11: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> tx_q);
endmodule

// File: rtl/abh_rx.sv
module abh_rx
    import abh_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          line,
    input  logic [DW-1:0] div,
    output rx_frame_t     frame,
    output logic          frame_v
);
    rx_state_t     st;
    logic          prev;
    logic [DW-1:0] cnt;
    logic [2:0]    nbit;
    logic [7:0]    sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= RX_IDLE;
            prev    <= 1'b1;
            cnt     <= '0;
            nbit    <= '0;
            sh      <= '0;
            frame   <= '0;
            frame_v <= 1'b0;
        end else if (!en) begin
            st      <= RX_IDLE;
            prev    <= line;
            frame_v <= 1'b0;
        end else begin
            prev    <= line;
            frame_v <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (prev && !line) begin
                        st  <= RX_START;
                        cnt <= div >> 1;
                    end
                end
                RX_START: begin
                    if (cnt == '0) begin
                        if (!line) begin
                            st   <= RX_DATA;
                            cnt  <= div - DW'(1);
                            nbit <= '0;
                        end else begin
                            st <= RX_IDLE;
                        end
                    end else begin
                        cnt <= cnt - DW'(1);
                    end
                end
                RX_DATA: begin
                    if (cnt == '0) begin
                        sh   <= {line, sh[7:1]};
                        cnt  <= div - DW'(1);
                        nbit <= nbit + 3'd1;
                        if (nbit == 3'd7) st <= RX_STOP;
                    end else begin
                        cnt <= cnt - DW'(1);
                    end
                end
                RX_STOP: begin
                    if (cnt == '0) begin
                        frame_v <= 1'b1;
                        frame   <= '{data: sh, stop_ok: line};
                        st      <= RX_IDLE;
                    end else begin
                        cnt <= cnt - DW'(1);
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    // R7: each received character is reported exactly once
    assert_frame_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        frame_v |=> !frame_v);
endmodule

// File: rtl/autobaud_handshake.sv
module autobaud_handshake
    import abh_pkg::*;
#(
    parameter int MIN_DIV      = 1000,
    parameter int MAX_DIV      = 2700,
    parameter int TIMEOUT_CLKS = 2500000,
    parameter int SYNC_STAGES  = 2,
    localparam int DW          = $clog2(MAX_DIV + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_i,
    output logic          tx_o,
    output logic          locked_o,
    output logic          err_o,
    output logic [DW-1:0] div_o
);
    localparam int CW = $clog2(LOW_BITS * (MAX_DIV + 1) + 1) + 1;
    localparam int TW = $clog2(TIMEOUT_CLKS + 1);

    hs_state_t     st;
    logic          rx_s;
    logic          meas_v;
    logic [CW-1:0] meas_per;
    logic          in_range;
    logic          tx_start;
    logic          tx_busy;
    logic          tx_done;
    rx_frame_t     frame;
    logic          frame_v;
    logic [TW-1:0] tmo;
    logic [DW-1:0] div_q;
    logic          err_q;

    abh_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d(rx_i), .q(rx_s)
    );

    abh_meter #(.CW(CW)) u_meter (
        .clk(clk), .rst(rst), .en(st == ST_MEASURE), .line(rx_s),
        .meas_v(meas_v), .meas_per(meas_per)
    );

    abh_tx #(.DW(DW)) u_tx (
        .clk(clk), .rst(rst), .start(tx_start), .data(SIGN_BYTE), .div(div_q),
        .tx(tx_o), .busy(tx_busy), .done(tx_done)
    );

    abh_rx #(.DW(DW)) u_rx (
        .clk(clk), .rst(rst), .en(st == ST_CONFIRM), .line(rx_s), .div(div_q),
        .frame(frame), .frame_v(frame_v)
    );

    assign in_range = (meas_per >= CW'(MIN_DIV)) && (meas_per <= CW'(MAX_DIV));
    assign tx_start = (st == ST_SEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_MEASURE;
            div_q <= '0;
            err_q <= 1'b0;
            tmo   <= '0;
        end else begin
            case (st)
                ST_MEASURE: begin
                    if (meas_v) begin
                        if (in_range) begin
                            div_q <= DW'(meas_per);
                            err_q <= 1'b0;
                            st    <= ST_SEND;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_SEND: st <= ST_WAIT_TX;
                ST_WAIT_TX: begin
                    if (tx_done) begin
                        st  <= ST_CONFIRM;
                        tmo <= '0;
                    end
                end
                ST_CONFIRM: begin
                    if (frame_v) begin
                        if (frame.data == CONFIRM_BYTE && frame.stop_ok) begin
                            st <= ST_LOCKED;
                        end else begin
                            err_q <= 1'b1;
                            st    <= ST_MEASURE;
                        end
                    end else if (tmo == TW'(TIMEOUT_CLKS - 1)) begin
                        err_q <= 1'b1;
                        st    <= ST_MEASURE;
                    end else begin
                        tmo <= tmo + TW'(1);
                    end
                end
                ST_LOCKED: st <= ST_LOCKED;
                default:   st <= ST_MEASURE;
            endcase
        end
    end

    assign locked_o = (st == ST_LOCKED);
    assign err_o    = err_q;
    assign div_o    = div_q;

    // R6: lock is permanent until reset and never coexists with an error
    assert_locked_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        locked_o |=> locked_o);
    assert_locked_no_err_R6: assert property (@(posedge clk) disable iff (rst)
        locked_o |-> !err_o);
    // R4: a locked divisor always lies inside the legal window
    assert_div_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        locked_o |-> (div_o >= DW'(MIN_DIV) && div_o <= DW'(MAX_DIV)));
    // R9: divisor only moves while measuring
    assert_div_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (st != ST_MEASURE) |=> $stable(div_o));
    // R5: the transmit line only starts a character for the sign
    assert_sign_after_accept_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_o) |-> (st == ST_WAIT_TX));
    // R10: acceptance leaves the error flag clear
    assert_err_cleared_R10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SEND) |-> !err_o);
endmodule

// File: tb/autobaud_handshake_tb.sv
module autobaud_handshake_tb;
    localparam int MIN_DIV = 8;
    localparam int MAX_DIV = 40;
    localparam int TMO     = 2000;
    localparam int DW      = $clog2(MAX_DIV + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx  = 1'b1;
    logic          tx_o;
    logic          locked_o;
    logic          err_o;
    logic [DW-1:0] div_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    autobaud_handshake #(
        .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV), .TIMEOUT_CLKS(TMO), .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst(rst), .rx_i(rx), .tx_o(tx_o),
        .locked_o(locked_o), .err_o(err_o), .div_o(div_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        rx  = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_tx_fall(input int maxc, output bit found);
        found = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (tx_o == 1'b0) begin
                found = 1'b1;
                break;
            end
        end
    endtask

    task automatic measure_tx_low(output int n);
        n = 0;
        while (tx_o == 1'b0) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input int p);
        rx = 1'b0;
        repeat (p) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (p) @(negedge clk);
        end
        rx = 1'b1;
        repeat (p) @(negedge clk);
    endtask

    // Low run of l clocks, then high; expects acceptance with divisor exp.
    task automatic accept(input int l, input int exp, input string tag);
        bit found;
        int n;
        rx = 1'b0;
        repeat (l) @(negedge clk);
        rx = 1'b1;
        wait_tx_fall(300, found);
        check(found, {tag, " sign started"}, int'(found), 1);
        check(int'(div_o) == exp, {tag, " divisor"}, int'(div_o), exp);
        measure_tx_low(n);
        check(n == 9 * exp, "R5 sign low run", n, 9 * exp);
        repeat (exp + 5) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bit found;
        int lows;

        // R1: reset state
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(tx_o === 1'b1, "R1 tx idle in reset", int'(tx_o), 1);
        check(locked_o === 1'b0 && err_o === 1'b0, "R1 flags in reset",
              int'({locked_o, err_o}), 0);
        check(div_o === '0, "R1 divisor in reset", int'(div_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(tx_o === 1'b1 && locked_o === 1'b0 && err_o === 1'b0,
              "R1 after reset", int'({tx_o, locked_o, err_o}), 4);

        // R2 / R5: sweep of low-run lengths across the whole window
        for (int l = 9 * MIN_DIV - 4; l <= 9 * MAX_DIV + 4; l += 4) begin
            do_reset();
            accept(l, (l + 4) / 9, "R2 sweep");
            check(err_o == 1'b0, "R2 no error on legal rate", int'(err_o), 0);
        end

        // R2: rounding boundary, 9p+4 rounds down, 9p+5 rounds up
        do_reset();
        accept(9 * 15 + 4, 15, "R2 round down");
        do_reset();
        accept(9 * 15 + 5, 16, "R2 round up");

        // R4: below and above the window, then R10 clears on acceptance
        do_reset();
        rx = 1'b0;
        repeat (9 * (MIN_DIV - 1)) @(negedge clk);
        rx = 1'b1;
        wait_tx_fall(300, found);
        check(!found, "R4 too fast no sign", int'(found), 0);
        check(err_o == 1'b1, "R4 too fast error", int'(err_o), 1);
        rx = 1'b0;
        repeat (9 * (MAX_DIV + 1)) @(negedge clk);
        rx = 1'b1;
        wait_tx_fall(300, found);
        check(!found, "R4 too slow no sign", int'(found), 0);
        check(err_o == 1'b1, "R10 error held", int'(err_o), 1);
        accept(180, 20, "R4 retry");
        check(err_o == 1'b0, "R10 error cleared on accept", int'(err_o), 0);

        // R3: high gap shorter than a bit discards the first run
        do_reset();
        rx = 1'b0;
        repeat (180) @(negedge clk);
        rx = 1'b1;
        repeat (10) @(negedge clk);
        accept(270, 30, "R3 short gap");

        // R6: confirm byte locks
        send_byte(8'h55, 30);
        repeat (5) @(negedge clk);
        check(locked_o == 1'b1, "R6 locked", int'(locked_o), 1);
        check(err_o == 1'b0, "R6 no error", int'(err_o), 0);

        // R6 / R11: further zeros while locked change nothing and nothing is sent
        lows = 0;
        fork
            begin
                send_byte(8'h00, 30);
                send_byte(8'h00, 17);
            end
            begin
                for (int i = 0; i < 470; i++) begin
                    @(negedge clk);
                    if (tx_o == 1'b0) lows++;
                end
            end
        join
        check(lows == 0, "R11 silent while locked", lows, 0);
        check(locked_o == 1'b1 && int'(div_o) == 30, "R6 lock sticky",
              int'(div_o), 30);

        // R9: zero character at another rate while the sign is going out
        do_reset();
        rx = 1'b0;
        repeat (180) @(negedge clk);
        rx = 1'b1;
        wait_tx_fall(300, found);
        check(found, "R9 sign started", int'(found), 1);
        send_byte(8'h00, 12);
        check(int'(div_o) == 20, "R9 divisor held during sign", int'(div_o), 20);
        while (tx_o == 1'b0) @(negedge clk);
        repeat (25) @(negedge clk);
        check(int'(div_o) == 20, "R9 divisor held after sign", int'(div_o), 20);
        send_byte(8'h55, 20);
        repeat (5) @(negedge clk);
        check(locked_o == 1'b1, "R9 locks at first rate", int'(locked_o), 1);

        // R7: wrong confirm byte
        do_reset();
        accept(180, 20, "R7 setup");
        send_byte(8'hAA, 20);
        repeat (5) @(negedge clk);
        check(err_o == 1'b1, "R7 bad byte error", int'(err_o), 1);
        check(locked_o == 1'b0, "R7 bad byte not locked", int'(locked_o), 0);
        accept(144, 16, "R7 remeasure");
        check(err_o == 1'b0, "R10 cleared after bad byte", int'(err_o), 0);

        // R7: 0x55 framed with a low stop bit
        rx = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = i[0] ? 1'b0 : 1'b1;
            repeat (16) @(negedge clk);
        end
        repeat (16) @(negedge clk);
        rx = 1'b1;
        repeat (20) @(negedge clk);
        check(err_o == 1'b1 && locked_o == 1'b0, "R7 bad stop bit",
              int'({err_o, locked_o}), 2);

        // R8: silence past the timeout
        accept(225, 25, "R8 setup");
        repeat (TMO + 50) @(negedge clk);
        check(err_o == 1'b1, "R8 timeout error", int'(err_o), 1);
        check(locked_o == 1'b0, "R8 timeout not locked", int'(locked_o), 0);
        accept(9 * 33, 33, "R8 retry");
        send_byte(8'h55, 33);
        repeat (5) @(negedge clk);
        check(locked_o == 1'b1 && err_o == 1'b0, "R8 retry locks",
              int'({locked_o, err_o}), 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule